// File: doc/BRIEF.md
# Two-Wire Programming Link Master Transceiver

This block is the controlling end of a synchronous two-wire debug and programming link. It owns the link clock line and shares a bidirectional data line with the target. Each accepted send request becomes one framed character on the wire. Each accepted receive request turns the data line around, clocks the target until a framed character appears, and returns the byte with an error flag.

A separate request runs the link-entry sequence. The block first holds the data line high with both pins driven. It then gives a fixed number of clock pulses with data still high. It ends by sending a fixed two-byte command that programs the target's guard time. Instruction decoding and memory programming are done by logic outside the block, which works at byte level through the send and receive handshakes.

The link clock runs from a parameterised divider. Each half period of the link clock lasts `HALF_DIV` system clocks.

Top module: `tw_link_master`

## Requirements
- R1: A sent character takes twelve link-clock cells. The data line carries, in this order: a low start bit, the eight data bits with the least significant bit first, an even-parity bit over those eight bits (high when the byte has an odd number of ones), and two high stop bits.
- R2: `link_dout` changes only while `link_clk` is high or in the same cycle that `link_clk` falls. It never changes in the cycle `link_clk` rises, so the target can sample on the rising edge.
- R3: Every low phase and every in-frame high phase of `link_clk` lasts exactly `HALF_DIV` system clocks. A send takes 24×`HALF_DIV` cycles from acceptance to `tx_ack`.
- R4: During a receive, `link_oe` is low. The block keeps clocking and samples `link_din` at the end of each cell's high phase. It treats the first low sample as the start bit. After `HUNT_LIMIT` (256) cells with no start bit, it pulses `rx_valid` with `rx_err` high and `rx_data` 0x00.
- R5: A received character with correct parity and two high stop bits is reported with `rx_data` equal to the eight data bits (the first bit is the least significant) and `rx_err` low. A start bit found in the last allowed hunting cell is still accepted.
- R6: If the received parity bit does not match even parity, or either stop bit samples low, the byte is discarded. `rx_valid` then comes with `rx_err` high and `rx_data` 0x00.
- R7: On `entry_req`, the block drives both pins with the clock high and the data high for `SETTLE_CYC` cycles. It then gives `ENTRY_PULSES` (16) clock pulses with the data high, then sends the characters 0xC2 and 0x02. None of this produces `tx_ack`.
- R8: `tx_ack` and `rx_valid` are single-cycle pulses. `tx_ack` comes after the last stop cell of a requested send.
- R9: While `busy` is high, `entry_req`, `tx_valid` and `rx_req` are ignored: no extra character is sent and the data driver is not released.
- R10: When idle, `link_clk` is high. After a send or an entry sequence, the data line stays driven high (with `IDLE_DRIVE`=1). After reset or a receive, the data line is released.
- R11: Requests that arrive in the same idle cycle are served in the order entry, then send, then receive. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | Start the link-entry sequence |
| tx_valid | input | 1 | Send request for `tx_data` |
| tx_data | input | 8 | Byte to send |
| tx_ack | output | 1 | One-cycle pulse when a requested send is complete |
| rx_req | input | 1 | Receive request |
| rx_valid | output | 1 | One-cycle pulse when a receive ends |
| rx_data | output | 8 | Received byte, 0x00 on error |
| rx_err | output | 1 | Receive failed: parity, stop bit or no start bit |
| busy | output | 1 | An operation is in progress |
| link_clk | output | 1 | Link clock line |
| link_dout | output | 1 | Data value driven onto the link |
| link_oe | output | 1 | Data driver enable |
| link_din | input | 1 | Data value read from the link |

## Verification
Some properties are checked by the assertions on every cycle: data is stable when the link clock rises, each low phase has its exact width, the clock is high whenever the block is idle, the driver is released whenever a receive result appears, results are single-cycle pulses, a failed receive carries a zero byte, and activity starts only from a request. The bench scenarios cover what needs a target model and a reference. They cover the bit order and parity of every character (including the entry bytes), the sixteen entry pulses, start-bit hunting at zero, small and maximum delays, the timeout after 256 cells, parity and stop-bit faults, request priority, and requests ignored in the middle of a frame.

// File: rtl/tw_link_pkg.sv
package tw_link_pkg;

   localparam int FRAME_BITS = 12;
   localparam int RX_BITS    = 11;
   localparam logic START_LVL = 1'b0;
   localparam logic [7:0] ENTRY_B0 = 8'hC2;
   localparam logic [7:0] ENTRY_B1 = 8'h02;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_ENTRY,
      ST_TX,
      ST_HUNT,
      ST_RX
   } seq_state_t;

   typedef enum logic [1:0] {
      ENT_NONE,
      ENT_FIRST,
      ENT_SECOND
   } ent_stage_t;

   // bit 0 goes on the wire first
   function automatic logic [FRAME_BITS-1:0] make_frame(input logic [7:0] d);
      return {2'b11, ^d, d, START_LVL};
   endfunction

endpackage

// File: rtl/tw_half_timer.sv
module tw_half_timer #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic link_clk,
   output logic cell_end
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

   logic          active;
   logic          lo;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         lo     <= 1'b0;
         cnt    <= '0;
      end else if (launch) begin
         active <= 1'b1;
         lo     <= 1'b1;
         cnt    <= '0;
      end else if (active) begin
         if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (lo) lo <= 1'b0;
            else    active <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign cell_end = active & ~lo & (cnt == CNT_LAST);
   assign link_clk = ~lo;

endmodule

// File: rtl/tw_frame_seq.sv
module tw_frame_seq
   import tw_link_pkg::*;
#(
   parameter int HUNT_LIMIT   = 256,
   parameter int ENTRY_PULSES = 16,
   parameter int SETTLE_CYC   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       entry_req,
   input  logic       tx_valid,
   input  logic [7:0] tx_data,
   input  logic       rx_req,
   input  logic       cell_end,
   input  logic       din,
   output logic       launch,
   output logic       dout,
   output logic       oe,
   output logic       busy,
   output logic       tx_ack,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       rx_err
);
   localparam int BC_MAX = (ENTRY_PULSES > FRAME_BITS) ? ENTRY_PULSES : FRAME_BITS;
   localparam int BCW    = $clog2(BC_MAX);
   localparam int HCW    = (HUNT_LIMIT > 1) ? $clog2(HUNT_LIMIT) : 1;
   localparam int SCW    = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [BCW-1:0] TX_LAST     = BCW'(FRAME_BITS - 1);
   localparam logic [BCW-1:0] RX_LAST     = BCW'(RX_BITS - 1);
   localparam logic [BCW-1:0] ENT_LAST    = BCW'(ENTRY_PULSES - 1);
   localparam logic [HCW-1:0] HUNT_LAST   = HCW'(HUNT_LIMIT - 1);
   localparam logic [SCW-1:0] SETTLE_LAST = SCW'(SETTLE_CYC - 1);

   seq_state_t             state;
   ent_stage_t             ent;
   logic [FRAME_BITS-1:0]  sh;
   logic [RX_BITS-1:0]     rx_sh;
   logic [RX_BITS-1:0]     rx_full;
   logic [BCW-1:0]         bit_cnt;
   logic [HCW-1:0]         hunt_cnt;
   logic [SCW-1:0]         settle_cnt;
   logic                   rx_ok;

   assign rx_full = {din, rx_sh[RX_BITS-1:1]};
   assign rx_ok   = ((^rx_full[7:0]) == rx_full[8]) & rx_full[9] & rx_full[10];
   assign busy    = (state != ST_IDLE);

   always_comb begin
      case (state)
         ST_IDLE:   launch = !entry_req && (tx_valid || rx_req);
         ST_SETTLE: launch = (settle_cnt == SETTLE_LAST);
         ST_ENTRY:  launch = cell_end;
         ST_TX:     launch = cell_end && ((bit_cnt != TX_LAST) || (ent == ENT_FIRST));
         ST_HUNT:   launch = cell_end && (!din || (hunt_cnt != HUNT_LAST));
         ST_RX:     launch = cell_end && (bit_cnt != RX_LAST);
         default:   launch = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ent        <= ENT_NONE;
         sh         <= '1;
         rx_sh      <= '0;
         bit_cnt    <= '0;
         hunt_cnt   <= '0;
         settle_cnt <= '0;
         dout       <= 1'b1;
         oe         <= 1'b0;
         tx_ack     <= 1'b0;
         rx_valid   <= 1'b0;
         rx_data    <= '0;
         rx_err     <= 1'b0;
      end else begin
         tx_ack   <= 1'b0;
         rx_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (entry_req) begin
                  state      <= ST_SETTLE;
                  oe         <= 1'b1;
                  dout       <= 1'b1;
                  settle_cnt <= '0;
               end else if (tx_valid) begin
                  state   <= ST_TX;
                  ent     <= ENT_NONE;
                  sh      <= make_frame(tx_data);
                  dout    <= START_LVL;
                  oe      <= 1'b1;
                  bit_cnt <= '0;
               end else if (rx_req) begin
                  state    <= ST_HUNT;
                  oe       <= 1'b0;
                  hunt_cnt <= '0;
               end
            end
            ST_SETTLE: begin
               settle_cnt <= settle_cnt + 1'b1;
               if (settle_cnt == SETTLE_LAST) begin
                  state   <= ST_ENTRY;
                  bit_cnt <= '0;
               end
            end
            ST_ENTRY: begin
               if (cell_end) begin
                  if (bit_cnt == ENT_LAST) begin
                     state   <= ST_TX;
                     ent     <= ENT_FIRST;
                     sh      <= make_frame(ENTRY_B0);
                     dout    <= START_LVL;
                     bit_cnt <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_TX: begin
               if (cell_end) begin
                  if (bit_cnt == TX_LAST) begin
                     if (ent == ENT_FIRST) begin
                        ent     <= ENT_SECOND;
                        sh      <= make_frame(ENTRY_B1);
                        dout    <= START_LVL;
                        bit_cnt <= '0;
                     end else begin
                        state  <= ST_IDLE;
                        dout   <= 1'b1;
                        tx_ack <= (ent == ENT_NONE);
                        ent    <= ENT_NONE;
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     dout    <= sh[1];
                     sh      <= sh >> 1;
                  end
               end
            end
            ST_HUNT: begin
               if (cell_end) begin
                  if (!din) begin
                     state   <= ST_RX;
                     bit_cnt <= '0;
                  end else if (hunt_cnt == HUNT_LAST) begin
                     state    <= ST_IDLE;
                     rx_valid <= 1'b1;
                     rx_err   <= 1'b1;
                     rx_data  <= '0;
                  end else begin
                     hunt_cnt <= hunt_cnt + 1'b1;
                  end
               end
            end
            ST_RX: begin
               if (cell_end) begin
                  rx_sh <= rx_full;
                  if (bit_cnt == RX_LAST) begin
                     state    <= ST_IDLE;
                     rx_valid <= 1'b1;
                     rx_err   <= ~rx_ok;
                     rx_data  <= rx_ok ? rx_full[7:0] : 8'h00;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tw_link_master.sv
module tw_link_master #(
   parameter int HALF_DIV     = 4,
   parameter int HUNT_LIMIT   = 256,
   parameter int ENTRY_PULSES = 16,
   parameter int SETTLE_CYC   = 8,
   parameter bit IDLE_DRIVE   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       entry_req,
   input  logic       tx_valid,
   input  logic [7:0] tx_data,
   output logic       tx_ack,
   input  logic       rx_req,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       rx_err,
   output logic       busy,
   output logic       link_clk,
   output logic       link_dout,
   output logic       link_oe,
   input  logic       link_din
);
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (HUNT_LIMIT < 1) begin : g_bad_hunt
      $error("HUNT_LIMIT must be at least 1");
   end
   if (ENTRY_PULSES < 1) begin : g_bad_pulses
      $error("ENTRY_PULSES must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   logic launch;
   logic cell_end;
   logic seq_oe;

   tw_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .link_clk (link_clk),
      .cell_end (cell_end)
   );

   tw_frame_seq #(
      .HUNT_LIMIT   (HUNT_LIMIT),
      .ENTRY_PULSES (ENTRY_PULSES),
      .SETTLE_CYC   (SETTLE_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .entry_req (entry_req),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .rx_req    (rx_req),
      .cell_end  (cell_end),
      .din       (link_din),
      .launch    (launch),
      .dout      (link_dout),
      .oe        (seq_oe),
      .busy      (busy),
      .tx_ack    (tx_ack),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_err    (rx_err)
   );

   if (IDLE_DRIVE) begin : g_hold_line
      assign link_oe = seq_oe;
   end else begin : g_release_line
      assign link_oe = seq_oe & busy;
   end

endmodule

// File: rtl/tw_link_checker.sv
module tw_link_checker #(
   parameter int HALF_DIV = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       entry_req,
   input logic       tx_valid,
   input logic       rx_req,
   input logic       tx_ack,
   input logic       rx_valid,
   input logic [7:0] rx_data,
   input logic       rx_err,
   input logic       busy,
   input logic       link_clk,
   input logic       link_dout,
   input logic       link_oe
);
   logic [15:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_cnt <= '0;
      else if (link_clk)       low_cnt <= '0;
      else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
   end

   p_rise_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_clk) |-> $stable(link_dout));

   p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_clk) |-> (low_cnt == 16'(HALF_DIV)));

   p_rx_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !link_oe);

   p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_err) |-> (rx_data == 8'h00));

   p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ack |=> !tx_ack);

   p_rxv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_start_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(entry_req || tx_valid || rx_req));

   p_idle_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> link_clk);

endmodule

bind tw_link_master tw_link_checker #(.HALF_DIV(HALF_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .entry_req (entry_req),
   .tx_valid  (tx_valid),
   .rx_req    (rx_req),
   .tx_ack    (tx_ack),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .rx_err    (rx_err),
   .busy      (busy),
   .link_clk  (link_clk),
   .link_dout (link_dout),
   .link_oe   (link_oe)
);

// File: tb/tb_tw_link_master.sv
`timescale 1ns/1ps
module tb_tw_link_master;
   localparam int HALF   = 4;
   localparam int HUNT   = 256;
   localparam int PULSES = 16;
   localparam int SETTLE = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       entry_req = 1'b0;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       rx_req = 1'b0;
   logic       link_din = 1'b1;
   logic       tx_ack, rx_valid, rx_err, busy, link_clk, link_dout, link_oe;
   logic [7:0] rx_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_tx[$];
   logic [8:0] exp_rx[$];
   int         lead_q[$];
   logic       rx_bits[$];
   int  frames_seen = 0;
   int  ack_count = 0;
   int  hunt_edges = 0;
   bit  rx_active = 1'b0;

   always #4 clk = ~clk;

   tw_link_master #(
      .HALF_DIV(HALF), .HUNT_LIMIT(HUNT), .ENTRY_PULSES(PULSES),
      .SETTLE_CYC(SETTLE), .IDLE_DRIVE(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ack(tx_ack), .rx_req(rx_req), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_err(rx_err), .busy(busy), .link_clk(link_clk),
      .link_dout(link_dout), .link_oe(link_oe), .link_din(link_din)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // transmit monitor: decodes characters seen on rising link clock
   bit         in_frame = 1'b0;
   int         nbit = 0;
   int         ones_run = 0;
   logic [11:0] fbits;
   always @(posedge link_clk) begin
      if (link_oe) begin
         if (!in_frame) begin
            if (link_dout == 1'b0) begin
               in_frame = 1'b1; fbits = '0; nbit = 1;
               lead_q.push_back(ones_run); ones_run = 0;
            end else ones_run++;
         end else begin
            fbits[nbit] = link_dout; nbit++;
            if (nbit == 12) begin
               in_frame = 1'b0;
               frames_seen++;
               if (exp_tx.size() == 0) begin
                  check(1'b0, "R9 unexpected character", int'(fbits[8:1]), 0);
               end else begin
                  logic [7:0] e;
                  e = exp_tx.pop_front();
                  check(fbits[8:1] == e, "R1 data bits", int'(fbits[8:1]), int'(e));
                  check(fbits[9] == ^e, "R1 parity bit", int'(fbits[9]), int'(^e));
                  check(fbits[11:10] == 2'b11, "R1 stop bits", int'(fbits[11:10]), 3);
               end
            end
         end
      end
   end

   // target model: presents a new bit at each falling link clock while receiving
   always @(negedge link_clk) begin
      if (rx_active) begin
         hunt_edges++;
         if (rx_bits.size() != 0) link_din <= rx_bits.pop_front();
         else                     link_din <= 1'b1;
      end
   end

   // receive scoreboard
   always @(negedge clk) begin
      if (tx_ack) ack_count++;
      if (rx_valid) begin
         if (exp_rx.size() == 0) check(1'b0, "R5 unexpected result", int'(rx_data), 0);
         else begin
            logic [8:0] e;
            e = exp_rx.pop_front();
            check(rx_err == e[8], "R6 error flag", int'(rx_err), int'(e[8]));
            check(rx_data == e[7:0], "R5 received byte", int'(rx_data), int'(e[7:0]));
         end
      end
   end

   task automatic send_byte(input logic [7:0] b, input bit inject);
      int cyc, lows;
      @(negedge clk);
      while (busy) @(negedge clk);
      exp_tx.push_back(b);
      tx_data = b; tx_valid = 1'b1;
      cyc = 0; lows = 0;
      do begin
         @(negedge clk);
         cyc++;
         tx_valid = 1'b0; rx_req = 1'b0; entry_req = 1'b0;
         if (inject && cyc == 10) begin
            tx_valid = 1'b1; tx_data = 8'h3C; rx_req = 1'b1; entry_req = 1'b1;
         end
         if (!link_clk) lows++;
      end while (!tx_ack && cyc < 2000);
      check(cyc == 24*HALF + 1, "R3 send duration", cyc, 24*HALF + 1);
      check(lows == 12*HALF, "R3 low-phase cycles", lows, 12*HALF);
      @(negedge clk);
      check(!tx_ack, "R8 tx_ack single cycle", int'(tx_ack), 0);
      check(!busy && link_clk && link_oe && link_dout, "R10 idle after send",
            int'({busy, link_clk, link_oe, link_dout}), 7);
   endtask

   task automatic load_rx(input int idle, input logic [7:0] d,
                          input bit par_flip, input bit s1_low, input bit s2_low);
      rx_bits.delete();
      for (int i = 0; i < idle; i++) rx_bits.push_back(1'b1);
      rx_bits.push_back(1'b0);
      for (int i = 0; i < 8; i++) rx_bits.push_back(d[i]);
      rx_bits.push_back((^d) ^ par_flip);
      rx_bits.push_back(!s1_low);
      rx_bits.push_back(!s2_low);
   endtask

   task automatic recv(input string tag, input bit e_err, input logic [7:0] e_data,
                       input int e_edges);
      int cyc;
      @(negedge clk);
      while (busy) @(negedge clk);
      exp_rx.push_back({e_err, e_data});
      hunt_edges = 0; rx_active = 1'b1;
      rx_req = 1'b1;
      @(negedge clk);
      rx_req = 1'b0;
      check(!link_oe, {tag, " R4 line released"}, int'(link_oe), 0);
      cyc = 0;
      while (!rx_valid && cyc < 20000) begin @(negedge clk); cyc++; end
      check(hunt_edges == e_edges, {tag, " clock cells"}, hunt_edges, e_edges);
      @(negedge clk);
      check(!rx_valid, "R8 rx_valid single cycle", int'(rx_valid), 0);
      check(!link_oe && link_clk, "R10 idle after receive", int'({link_oe, link_clk}), 1);
      rx_active = 1'b0; link_din = 1'b1; rx_bits.delete();
   endtask

   initial begin
      int s;
      repeat (3) @(negedge clk);
      check(link_clk && !link_oe && !busy && !tx_ack && !rx_valid, "R10 reset state",
            int'({link_clk, link_oe, busy}), 4);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 + R11: entry with competing requests in the same cycle
      exp_tx.push_back(8'hC2); exp_tx.push_back(8'h02);
      ones_run = 0; lead_q.delete();
      entry_req = 1'b1; tx_valid = 1'b1; tx_data = 8'h77; rx_req = 1'b1;
      @(negedge clk);
      entry_req = 1'b0; tx_valid = 1'b0; rx_req = 1'b0;
      check(busy && link_oe && link_dout && link_clk, "R7 settle levels",
            int'({busy, link_oe, link_dout, link_clk}), 15);
      s = 1;
      while (link_clk && s < 100) begin @(negedge clk); s++; end
      check(s == SETTLE + 1, "R7 settle length", s - 1, SETTLE);
      while (busy) @(negedge clk);
      check(frames_seen == 2, "R11 only entry characters", frames_seen, 2);
      check(lead_q.size() == 2 && lead_q[0] == PULSES, "R7 entry pulses",
            lead_q.size() ? lead_q[0] : -1, PULSES);
      check(lead_q.size() == 2 && lead_q[1] == 0, "R7 second byte follows at once",
            lead_q.size() > 1 ? lead_q[1] : -1, 0);
      check(ack_count == 0, "R7 no ack for entry", ack_count, 0);

      // R1 / R3 / R8 sends with several patterns
      send_byte(8'h00, 1'b0);
      send_byte(8'hFF, 1'b0);
      send_byte(8'hA5, 1'b0);
      send_byte(8'h01, 1'b0);
      // R9: requests during a frame are ignored
      send_byte(8'h96, 1'b1);
      repeat (4 * HALF) @(negedge clk);
      check(frames_seen == 7, "R9 no extra character", frames_seen, 7);
      check(!busy && link_oe, "R9 driver kept", int'({busy, link_oe}), 1);
      check(ack_count == 5, "R8 one ack per send", ack_count, 5);

      // receives
      load_rx(0, 8'h5A, 1'b0, 1'b0, 1'b0);
      recv("R5 immediate start", 1'b0, 8'h5A, 12);
      load_rx(3, 8'h81, 1'b0, 1'b0, 1'b0);
      recv("R5 delayed start", 1'b0, 8'h81, 15);
      load_rx(HUNT - 1, 8'h33, 1'b0, 1'b0, 1'b0);
      recv("R5 start in last hunting cell", 1'b0, 8'h33, HUNT + 11);
      load_rx(1, 8'h7E, 1'b1, 1'b0, 1'b0);
      recv("R6 parity fault", 1'b1, 8'h00, 13);
      load_rx(0, 8'hC3, 1'b0, 1'b1, 1'b0);
      recv("R6 first stop low", 1'b1, 8'h00, 12);
      load_rx(2, 8'h10, 1'b0, 1'b0, 1'b1);
      recv("R6 second stop low", 1'b1, 8'h00, 14);
      rx_bits.delete();
      recv("R4 hunt timeout", 1'b1, 8'h00, HUNT);

      // R11: send wins over receive
      @(negedge clk);
      exp_tx.push_back(8'h4D);
      tx_data = 8'h4D; tx_valid = 1'b1; rx_req = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0; rx_req = 1'b0;
      check(link_oe, "R11 send over receive", int'(link_oe), 1);
      while (busy) @(negedge clk);
      check(frames_seen == 8 && exp_tx.size() == 0, "R11 character sent", frames_seen, 8);
      check(exp_rx.size() == 0, "R5 all results seen", exp_rx.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule